// File: doc/BRIEF.md
# Multi-Queue Write Port Selector

This block is the shared write side of a buffer that holds many independent queues behind one write port. Several such buffers can sit on one address bus. Each one owns a static device number, and only the buffer whose number matches the upper address bits takes a selection. A selection is made in a single clock cycle by raising the address enable. The chosen queue then stays current until the next selection.

Switching queues is pipelined so that the write bus never idles. The data presented in the cycle of a selection and in the cycle after it still lands in the queue that was current before. The full flag moves to the new queue one cycle ahead of the data path, so the writer sees the new queue's status before its first word goes there. The block emits a write strobe and a queue index for the storage behind it. For each queue it keeps an occupancy count, which the read side lowers through a per-queue pulse. An error pulse reports selections that come too close together.

Top module: `mq_write_port`

## Requirements
- R1: After reset no queue is selected: `full`, `wr_strobe` and `sel_err` are 0 and every occupancy count is 0.
- R2: On a clock edge with `addr_en` high and `wr_addr[7:5]` equal to `dev_id`, the queue numbered `wr_addr[4:0]` becomes selected. The state of `wr_en_n` has no effect on this. The selection holds until the next edge with `addr_en` high.
- R3: A write sampled on the selection edge or on the edge after it goes to the previously selected queue. From the second edge after the selection, writes go to the new queue. `wr_queue` carries the target queue while `wr_strobe` is high.
- R4: From the first edge after a selection, `full` shows the state of the newly selected queue.
- R5: A queue is full when its count equals `CAPACITY`. A write to a full queue is refused: `wr_strobe` stays 0 and the count does not change.
- R6: A selection whose upper bits differ from `dev_id` deselects the block. `full` drops to 0 from the first edge after it. `wr_strobe` stays 0 from the second edge after it.
- R7: If a selection edge directly follows another selection edge, `sel_err` is 1 for exactly the cycle after the second edge. The second selection still takes effect.
- R8: A high bit of `rd_pulse` on an edge lowers that queue's count by one. A read of an empty queue is ignored. A read and an accepted write to the same queue on one edge leave the count unchanged.
- R9: `wr_strobe` is high only when `wr_en_n` is 0, a queue is selected on the data path and that queue is not full. Each strobe raises the target queue's count by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_en | input | 1 | Selection strobe for `wr_addr` |
| wr_addr | input | 8 | Device number [7:5] and queue number [4:0] |
| dev_id | input | 3 | Static number of this device |
| wr_en_n | input | 1 | Write enable, active low |
| rd_pulse | input | NUM_QUEUES | One pulse per word removed from each queue |
| full | output | 1 | Full state of the queue selected for the flag |
| wr_strobe | output | 1 | A word is accepted on this edge |
| wr_queue | output | 5 | Queue that receives the accepted word |
| sel_err | output | 1 | Selections one cycle apart were seen |

## Verification
Two kinds of event can land on the same edge. In the first, a selection and a data write share an edge. The bench raises `addr_en` while `wr_en_n` is low and checks that the strobe still names the old queue for that cycle and the next, while `full` already follows the new queue. In the second, a read pulse and an accepted write hit the same queue on one edge. The result is judged afterwards through `full`: one more plain write must be enough to fill that queue.

// File: rtl/mqw_pkg.sv
package mqw_pkg;
   localparam int MQW_ADDR_W = 8;
   localparam int MQW_QSEL_W = 5;
   localparam int MQW_DEV_W  = MQW_ADDR_W - MQW_QSEL_W;
   localparam int MQW_QSPACE = 2 ** MQW_QSEL_W;

   typedef struct packed {
      logic                  valid;
      logic [MQW_QSEL_W-1:0] qid;
   } mqw_sel_t;
endpackage

// File: rtl/mqw_sel_pipe.sv
module mqw_sel_pipe
   import mqw_pkg::*;
#(
   parameter int NUM_QUEUES = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  addr_en,
   input  logic [MQW_ADDR_W-1:0] wr_addr,
   input  logic [MQW_DEV_W-1:0]  dev_id,
   output mqw_sel_t              flag_sel,
   output mqw_sel_t              data_sel,
   output logic                  sel_err
);
   logic     id_hit;
   logic     in_range;
   mqw_sel_t new_sel;
   mqw_sel_t flag_q, pend_q, data_q;
   logic     pend_ld, sel_d1, err_q;

   assign id_hit = (wr_addr[MQW_ADDR_W-1:MQW_QSEL_W] == dev_id);

   generate
      if (NUM_QUEUES == MQW_QSPACE) begin : g_full_space
         assign in_range = 1'b1;
      end else begin : g_part_space
         localparam logic [MQW_QSEL_W:0] NQ_V = (MQW_QSEL_W+1)'(NUM_QUEUES);
         assign in_range = ({1'b0, wr_addr[MQW_QSEL_W-1:0]} < NQ_V);
      end
   endgenerate

   always_comb begin
      new_sel.valid = id_hit & in_range;
      new_sel.qid   = wr_addr[MQW_QSEL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= '0;
         pend_q  <= '0;
         data_q  <= '0;
         pend_ld <= 1'b0;
         sel_d1  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         sel_d1  <= addr_en;
         err_q   <= addr_en & sel_d1;
         pend_ld <= addr_en;
         if (addr_en) begin
            flag_q <= new_sel;
            pend_q <= new_sel;
         end
         if (pend_ld) data_q <= pend_q;
      end
   end

   assign flag_sel = flag_q;
   assign data_sel = data_q;
   assign sel_err  = err_q;

   a_r3_data_lags_flag: assert property (@(posedge clk) disable iff (!rst_n)
      data_q == $past(flag_q));

   a_r4_flag_takes_new: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_en && id_hit && in_range) |=>
         (flag_q.valid && flag_q.qid == $past(wr_addr[MQW_QSEL_W-1:0])));

   a_r7_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err |-> $past(addr_en));
endmodule

// File: rtl/mqw_occ_bank.sv
module mqw_occ_bank #(
   parameter int NUM_QUEUES = 32,
   parameter int CAPACITY   = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_QUEUES-1:0] wr_inc,
   input  logic [NUM_QUEUES-1:0] rd_dec,
   output logic [NUM_QUEUES-1:0] full_vec
);
   localparam int              CNT_W = $clog2(CAPACITY + 1);
   localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

   genvar g;
   generate
      for (g = 0; g < NUM_QUEUES; g++) begin : g_q
         logic [CNT_W-1:0] cnt;
         logic             dec_ok;

         assign dec_ok      = rd_dec[g] & (cnt != '0);
         assign full_vec[g] = (cnt == CAP_V);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else begin
               case ({wr_inc[g], dec_ok})
                  2'b10:   cnt <= cnt + 1'b1;
                  2'b01:   cnt <= cnt - 1'b1;
                  default: cnt <= cnt;
               endcase
            end
         end

         a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CAP_V);

         a_r5_inc_only_when_room: assert property (@(posedge clk) disable iff (!rst_n)
            wr_inc[g] |-> (cnt != CAP_V));

         a_r8_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == '0 && rd_dec[g] && !wr_inc[g]) |=> (cnt == '0));
      end
   endgenerate
endmodule

// File: rtl/mq_write_port.sv
module mq_write_port
   import mqw_pkg::*;
#(
   parameter int NUM_QUEUES = 32,
   parameter int CAPACITY   = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  addr_en,
   input  logic [7:0]            wr_addr,
   input  logic [2:0]            dev_id,
   input  logic                  wr_en_n,
   input  logic [NUM_QUEUES-1:0] rd_pulse,
   output logic                  full,
   output logic                  wr_strobe,
   output logic [4:0]            wr_queue,
   output logic                  sel_err
);
   generate
      if (NUM_QUEUES < 1 || NUM_QUEUES > MQW_QSPACE) begin : g_bad_nq
         $error("NUM_QUEUES must lie in 1..%0d", MQW_QSPACE);
      end
      if (CAPACITY < 1) begin : g_bad_cap
         $error("CAPACITY must be at least 1");
      end
   endgenerate

   mqw_sel_t                flag_sel, data_sel;
   logic [NUM_QUEUES-1:0]   full_vec, wr_inc;
   logic [MQW_QSPACE-1:0]   full_ext, inc_ext;
   logic                    data_full;

   mqw_sel_pipe #(.NUM_QUEUES(NUM_QUEUES)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_en  (addr_en),
      .wr_addr  (wr_addr),
      .dev_id   (dev_id),
      .flag_sel (flag_sel),
      .data_sel (data_sel),
      .sel_err  (sel_err)
   );

   mqw_occ_bank #(.NUM_QUEUES(NUM_QUEUES), .CAPACITY(CAPACITY)) u_occ (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_inc   (wr_inc),
      .rd_dec   (rd_pulse),
      .full_vec (full_vec)
   );

   assign full_ext  = MQW_QSPACE'(full_vec);
   assign data_full = full_ext[data_sel.qid];
   assign full      = flag_sel.valid & full_ext[flag_sel.qid];
   assign wr_strobe = data_sel.valid & ~wr_en_n & ~data_full;
   assign wr_queue  = data_sel.qid;
   assign inc_ext   = MQW_QSPACE'(wr_strobe) << data_sel.qid;
   assign wr_inc    = inc_ext[NUM_QUEUES-1:0];

   a_r6_deselect_releases_full: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_en && wr_addr[7:5] != dev_id) |=> !full);

   a_r9_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> !wr_en_n);
endmodule

// File: tb/test_mq_write_port.sv
module test_mq_write_port;
   localparam int NQ  = 32;
   localparam int CAP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          addr_en = 1'b0;
   logic [7:0]    wr_addr = '0;
   logic [2:0]    dev_id = 3'd5;
   logic          wr_en_n = 1'b1;
   logic [NQ-1:0] rd_pulse = '0;
   logic          full, wr_strobe, sel_err;
   logic [4:0]    wr_queue;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   mq_write_port #(.NUM_QUEUES(NQ), .CAPACITY(CAP)) i_mq_write_port (
      .clk(clk), .rst_n(rst_n), .addr_en(addr_en), .wr_addr(wr_addr),
      .dev_id(dev_id), .wr_en_n(wr_en_n), .rd_pulse(rd_pulse),
      .full(full), .wr_strobe(wr_strobe), .wr_queue(wr_queue), .sel_err(sel_err)
   );

   // vector: {addr_en, wr_addr, wr_en_n, exp_strobe, exp_queue, exp_full}
   localparam logic [16:0] VEC [15] = '{
      {1'b1, 8'hA2, 1'b0, 1'b0, 5'd0, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b0, 5'd0, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b1, 5'd2, 1'b0},
      {1'b1, 8'hA9, 1'b0, 1'b1, 5'd2, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b1, 5'd2, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b1, 5'd9, 1'b0},
      {1'b0, 8'h00, 1'b1, 1'b0, 5'd0, 1'b0},
      {1'b1, 8'hA2, 1'b0, 1'b1, 5'd9, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b1, 5'd9, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b1, 5'd2, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b0, 5'd0, 1'b1},
      {1'b1, 8'hA9, 1'b0, 1'b0, 5'd0, 1'b1},
      {1'b0, 8'h00, 1'b0, 1'b0, 5'd0, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b1, 5'd9, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b0, 5'd0, 1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic ae, input logic [7:0] ad, input logic wen,
                      input logic [NQ-1:0] rd);
      @(negedge clk);
      addr_en  = ae;
      wr_addr  = ad;
      wr_en_n  = wen;
      rd_pulse = rd;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wr_en_n = 1'b0;
      #1;
      chk("R1 full after reset", full, 0);
      chk("R1 strobe after reset", wr_strobe, 0);
      chk("R1 sel_err after reset", sel_err, 0);

      // table walk: switching, pipelined data path, fill and block
      for (int i = 0; i < 15; i++) begin
         cyc(VEC[i][16], VEC[i][15:8], VEC[i][7], '0);
         chk($sformatf("R3 strobe v%0d", i), wr_strobe, VEC[i][6]);
         if (VEC[i][6]) chk($sformatf("R3 queue v%0d", i), wr_queue, VEC[i][5:1]);
         chk($sformatf("R4 R5 full v%0d", i), full, VEC[i][0]);
      end
      // state: queues 2 and 9 hold 4, queue 9 selected

      // R8 read lowers the count
      cyc(1'b0, 8'h00, 1'b1, NQ'(1) << 9);
      cyc(1'b0, 8'h00, 1'b1, '0);
      chk("R8 read clears full", full, 0);
      // R8 read and write on one edge
      cyc(1'b0, 8'h00, 1'b0, NQ'(1) << 9);
      chk("R8 strobe with read", wr_strobe, 1);
      chk("R9 queue with read", wr_queue, 9);
      cyc(1'b0, 8'h00, 1'b1, '0);
      chk("R8 count kept on read+write", full, 0);
      cyc(1'b0, 8'h00, 1'b0, '0);
      cyc(1'b0, 8'h00, 1'b1, '0);
      chk("R5 refilled", full, 1);

      // R8 read of empty queue 5 is ignored
      cyc(1'b0, 8'h00, 1'b1, NQ'(1) << 5);
      cyc(1'b1, 8'hA5, 1'b1, '0);
      cyc(1'b0, 8'h00, 1'b1, '0);
      chk("R2 select with write disabled", full, 0);
      for (int k = 0; k < 3; k++) begin
         cyc(1'b0, 8'h00, 1'b0, '0);
         chk("R9 strobe q5", wr_strobe, 1);
      end
      cyc(1'b0, 8'h00, 1'b1, '0);
      chk("R9 no strobe when disabled", wr_strobe, 0);
      chk("R8 three words after empty read", full, 0);
      cyc(1'b0, 8'h00, 1'b0, '0);
      cyc(1'b0, 8'h00, 1'b1, '0);
      chk("R8 fourth word fills", full, 1);
      cyc(1'b0, 8'h00, 1'b1, NQ'(1) << 5);
      cyc(1'b0, 8'h00, 1'b1, '0);
      chk("R8 read from full", full, 0);

      // R6 foreign device number
      cyc(1'b1, {3'b010, 5'd5}, 1'b1, '0);
      cyc(1'b0, 8'h00, 1'b0, '0);
      chk("R6 full released", full, 0);
      chk("R7 no error for spaced select", sel_err, 0);
      chk("R3 old path during deselect", wr_strobe, 1);
      chk("R3 old queue during deselect", wr_queue, 5);
      cyc(1'b0, 8'h00, 1'b0, '0);
      chk("R6 strobe stopped", wr_strobe, 0);
      chk("R6 full stays low", full, 0);

      // R7 back-to-back selections
      cyc(1'b1, 8'hA9, 1'b1, '0);
      chk("R7 quiet before pair", sel_err, 0);
      cyc(1'b1, 8'hA0, 1'b1, '0);
      chk("R7 quiet on first of pair", sel_err, 0);
      cyc(1'b0, 8'h00, 1'b0, '0);
      chk("R7 error pulse", sel_err, 1);
      chk("R7 second select honoured", full, 0);
      cyc(1'b0, 8'h00, 1'b0, '0);
      chk("R7 pulse ends", sel_err, 0);
      chk("R7 data to second queue", wr_strobe, 1);
      chk("R7 queue number", wr_queue, 0);

      // R1 reset again
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 full in reset", full, 0);
      chk("R1 strobe in reset", wr_strobe, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule